// File: doc/BRIEF.md
# Nibble-Addressed Double-Buffered Converter Register

This block is the digital front end of a 12-bit parallel-input converter, written for a single clock domain. A host writes the 12-bit code through an 8-bit data bus in pieces. Two address lines choose which of three 4-bit staging latches (low, middle, high) take the write, and which data pins feed them. The code can be loaded in three nibble writes, or as one byte plus one nibble. A separate active-low load strobe moves the assembled staging value into a 12-bit output latch, whose contents are the code presented to the converter.

Every strobe (chip select, write, load and clear) is active low and is sampled on the rising clock edge. A write takes effect at the edge where both chip select and write are sampled low. The output latch is governed by a three-state gate machine, evaluated from the strobes sampled at each edge. The machine is in `GATE_CLEAR` when clear is low. It is in `GATE_TRACK` when clear is high and load is low. In that state the output latch copies the staging latches as they stand after the same edge, including a write made at that edge. It is in `GATE_HOLD` when both clear and load are high, and the output latch keeps its value. Any state can move to any other at any edge. The only rule is that clear outranks load. Clear and the power-on reset zero the output latch. Clear leaves the staging latches untouched, so a later load restores the staged code.

Top module: `nibble_dac_front`

## Requirements
- R1: After power-on reset (`por_n` low), `dac_code` is 0x000 and all three staging nibbles are zero, so a load with no writes since reset gives 0x000.
- R2: A write with `addr` = 2'b11 stores `bus_d[3:0]` into code bits 11..8.
- R3: A write with `addr` = 2'b10 stores `bus_d[7:4]` into code bits 7..4.
- R4: A write with `addr` = 2'b01 stores `bus_d[3:0]` into code bits 3..0.
- R5: A write with `addr` = 2'b00 stores `bus_d[7:4]` into bits 7..4 and `bus_d[3:0]` into bits 3..0 in the same write.
- R6: When `cs_n` is high, or `wr_n` is high, the staging latches do not change, whatever `addr` and `bus_d` are.
- R7: If `load_n` is sampled low and `clr_n` high at an edge, `dac_code` after that edge equals the staging latches after that edge. This includes a write made at the same edge.
- R8: If both `load_n` and `clr_n` are sampled high at an edge, `dac_code` does not change at that edge.
- R9: Load acts regardless of `cs_n` and `wr_n`. With `cs_n` high and `load_n` low, only the output latch updates.
- R10: If `clr_n` is sampled low at an edge, `dac_code` is 0x000 after that edge, even when `load_n` is low, and regardless of `cs_n`.
- R11: Clear does not alter the staging latches. A later load with no writes in between restores the previously staged code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| bus_d | input | 8 | Parallel data bus |
| addr | input | 2 | Staging latch address |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| load_n | input | 1 | Output latch load gate, active low |
| clr_n | input | 1 | Clear of the output latch, active low |
| dac_code | output | 12 | Contents of the output latch |

## Verification
Wrong staging contents stay hidden while load is high. They show on `dac_code` one edge after load is next sampled low, so the bench follows each write with a load and reads the result one edge later. A gate machine in the wrong state shows up sooner. Either `dac_code` changes at an edge where it should hold, or it misses a same-edge write, and both are visible one cycle after the strobe. Clear followed by a bare load checks that clear reached only the output latch: a staging latch wrongly zeroed gives a wrong code at the first load after the clear.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
    localparam int NIB_W   = 4;
    localparam int NIB_CNT = 3;

    typedef enum logic [1:0] {
        GATE_HOLD  = 2'd0,
        GATE_TRACK = 2'd1,
        GATE_CLEAR = 2'd2
    } gate_e;
endpackage

// File: rtl/nibble_bank.sv
module nibble_bank #(
    parameter int NW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*NW-1:0] bus_d,
    input  logic [1:0]      addr,
    input  logic            cs_n,
    input  logic            wr_n,
    output logic [3*NW-1:0] bank_q,
    output logic [3*NW-1:0] bank_nxt
);
    localparam int CODE_W = 3 * NW;

    logic wr_go;
    assign wr_go = !cs_n && !wr_n;

    for (genvar g = 0; g < 3; g++) begin : g_nib
        logic          en;
        logic [NW-1:0] src;
        logic [NW-1:0] nib_q;

        if (g == 0) begin : g_low
            assign en  = wr_go && (addr == 2'b01 || addr == 2'b00);
            assign src = bus_d[NW-1:0];
        end else if (g == 1) begin : g_mid
            assign en  = wr_go && (addr == 2'b10 || addr == 2'b00);
            assign src = bus_d[2*NW-1:NW];
        end else begin : g_high
            assign en  = wr_go && (addr == 2'b11);
            assign src = bus_d[NW-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  nib_q <= '0;
            else if (en) nib_q <= src;
        end

        assign bank_q[g*NW +: NW]   = nib_q;
        assign bank_nxt[g*NW +: NW] = en ? src : nib_q;
    end

    // R6: a deselected bus leaves every staging nibble alone
    p_deselect_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(bank_q));
    // R6: write strobe high leaves every staging nibble alone
    p_nowrite_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(bank_q));
    // R2: high nibble taken from the low data pins
    p_high_steer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 2'b11) |=>
            bank_q[CODE_W-1 -: NW] == $past(bus_d[NW-1:0]));
    // R5: byte write fills low and middle together
    p_byte_steer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 2'b00) |=>
            bank_q[2*NW-1:0] == $past(bus_d));
endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic [CODE_W-1:0] bank_q,
    input  logic [CODE_W-1:0] bank_nxt,
    output logic [CODE_W-1:0] code_q
);
    import dac_front_pkg::*;

    gate_e state_q, state_nxt;

    always_comb begin
        if (!clr_n)       state_nxt = GATE_CLEAR;
        else if (!load_n) state_nxt = GATE_TRACK;
        else              state_nxt = GATE_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_CLEAR;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            unique case (state_nxt)
                GATE_CLEAR: code_q <= '0;
                GATE_TRACK: code_q <= bank_nxt;
                GATE_HOLD:  code_q <= code_q;
                default:    code_q <= '0;
            endcase
        end
    end

    // R10: clear wins over load and zeroes the output
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> code_q == '0);
    // R7: an open gate shows the staging value after the same edge
    p_track_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n) |=> code_q == bank_q);
    // R8: a closed gate holds the output
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n) |=> $stable(code_q));
    // R10: the gate machine records a clear
    p_state_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> state_q == GATE_CLEAR);
endmodule

// File: rtl/nibble_dac_front.sv
module nibble_dac_front (
    input  logic        clk,
    input  logic        por_n,
    input  logic [7:0]  bus_d,
    input  logic [1:0]  addr,
    input  logic        cs_n,
    input  logic        wr_n,
    input  logic        load_n,
    input  logic        clr_n,
    output logic [11:0] dac_code
);
    import dac_front_pkg::*;
    localparam int CODE_W = NIB_CNT * NIB_W;

    logic [CODE_W-1:0] bank_q;
    logic [CODE_W-1:0] bank_nxt;

    nibble_bank #(.NW(NIB_W)) u_bank (
        .clk      (clk),
        .rst_n    (por_n),
        .bus_d    (bus_d),
        .addr     (addr),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .bank_q   (bank_q),
        .bank_nxt (bank_nxt)
    );

    out_gate #(.CODE_W(CODE_W)) u_gate (
        .clk      (clk),
        .rst_n    (por_n),
        .load_n   (load_n),
        .clr_n    (clr_n),
        .bank_q   (bank_q),
        .bank_nxt (bank_nxt),
        .code_q   (dac_code)
    );
endmodule

// File: tb/sim_nibble_dac_front.sv
`timescale 1ns/1ps
module sim_nibble_dac_front;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [7:0]  bus_d = 8'h00;
    logic [1:0]  addr = 2'b00;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        load_n = 1'b1;
    logic        clr_n = 1'b1;
    logic [11:0] dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nibble_dac_front u0 (
        .clk(clk), .por_n(por_n), .bus_d(bus_d), .addr(addr),
        .cs_n(cs_n), .wr_n(wr_n), .load_n(load_n), .clr_n(clr_n),
        .dac_code(dac_code)
    );

    // {bus_d, addr, cs_n, wr_n, load_n, clr_n, 6'd0, expected code}
    localparam logic [31:0] VEC [16] = '{
        {8'hA5, 2'b11, 4'b0011, 6'd0, 12'h000}, // R2 write high, R8 hold
        {8'h3C, 2'b10, 4'b0011, 6'd0, 12'h000}, // R3 write middle
        {8'hE7, 2'b01, 4'b0011, 6'd0, 12'h000}, // R4 write low
        {8'h00, 2'b00, 4'b1101, 6'd0, 12'h537}, // R9 load with cs_n high
        {8'hFF, 2'b00, 4'b1011, 6'd0, 12'h537}, // R6 deselected write
        {8'hFF, 2'b00, 4'b1101, 6'd0, 12'h537}, // R6 bank unchanged
        {8'h9B, 2'b00, 4'b0011, 6'd0, 12'h537}, // R5 byte write, R8 hold
        {8'h00, 2'b00, 4'b1101, 6'd0, 12'h59B}, // R5 result
        {8'h42, 2'b11, 4'b0001, 6'd0, 12'h29B}, // R7 same-edge write and load
        {8'h00, 2'b11, 4'b0111, 6'd0, 12'h29B}, // R6 wr_n high
        {8'h00, 2'b00, 4'b1100, 6'd0, 12'h000}, // R10 clear beats load
        {8'h06, 2'b11, 4'b0010, 6'd0, 12'h000}, // R10 clear with select
        {8'h00, 2'b00, 4'b1111, 6'd0, 12'h000}, // R8 idle after clear
        {8'h00, 2'b00, 4'b1101, 6'd0, 12'h69B}, // R11 restore staged code
        {8'hC8, 2'b10, 4'b0001, 6'd0, 12'h6CB}, // R7 middle write while open
        {8'h00, 2'b00, 4'b1111, 6'd0, 12'h6CB}  // R8 gate closed
    };

    task automatic check(input logic [11:0] exp, input string req);
        n_chk++;
        if (dac_code !== exp) begin
            n_bad++;
            $display("FAIL %s: dac_code=%03h expected=%03h", req, dac_code, exp);
        end
    endtask

    task automatic drive(input logic [7:0] d, input logic [1:0] a,
                         input logic [3:0] strobes);
        bus_d  = d;
        addr   = a;
        cs_n   = strobes[3];
        wr_n   = strobes[2];
        load_n = strobes[1];
        clr_n  = strobes[0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(12'h000, "R1 reset");
        por_n = 1'b1;
        @(negedge clk);
        drive(8'h00, 2'b00, 4'b1101);
        @(negedge clk);
        check(12'h000, "R1 staging zero after reset");
        drive(8'h00, 2'b00, 4'b1111);
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][31:24], VEC[i][23:22], VEC[i][21:18]);
            @(negedge clk);
            check(VEC[i][11:0], $sformatf("R2-table step %0d", i));
        end

        // R11 clear leaves staging intact, then reset zeroes everything (R1)
        drive(8'h00, 2'b00, 4'b1110);
        @(negedge clk);
        check(12'h000, "R10 clear");
        drive(8'h00, 2'b00, 4'b1101);
        @(negedge clk);
        check(12'h6CB, "R11 load after clear");
        por_n = 1'b0;
        drive(8'h00, 2'b00, 4'b1111);
        @(negedge clk);
        check(12'h000, "R1 reset mid-run");
        por_n = 1'b1;
        @(negedge clk);
        drive(8'h00, 2'b00, 4'b1101);
        @(negedge clk);
        check(12'h000, "R1 staging cleared by reset");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule